// File: doc/BRIEF.md
# Weight-Stationary INT8 Multiply-Accumulate Grid

This block multiplies a signed 8-bit activation vector by a weight matrix that stays resident in a rectangular grid of multiply-accumulate cells. Each cell holds one weight. Activations travel one cell to the right per clock, and partial sums travel one cell downward per clock. Only the finished column sums leave through the bottom edge. A skew stage at the left edge delays row `r` by `r` clocks, and a de-skew stage at the bottom delays column `c` by `COLS-1-c` clocks. As a result, all columns of one result vector come out together. A matrix-matrix product is formed by streaming one column vector of the right-hand matrix per cycle.

Weights are written one grid row per cycle while `w_load` is high. A row is written only when no activation vector is still in flight, so results already in progress always use the old weights. Activation vectors enter on a valid/ready stream. Result vectors leave on a second valid/ready stream. When a result is offered but `res_ready` is low, the whole pipeline holds. Nothing new is accepted and the offered result stays unchanged until it is taken. A cycle with no accepted input sends a bubble through the grid, and a bubble never produces a result.

Top module: `sa_wsgrid`

## Requirements
- R1: After reset, `res_valid` and `w_take` are low and `act_ready` is high. Every stored weight is zero, so a vector sent before any load gives an all-zero result.
- R2: While `w_load` is high, each cycle with `w_take` high writes `w_row` into grid row 0, then row 1, and so on, wrapping after the last row. Weight column `c` is `w_row[8c+7:8c]`. The row pointer goes back to row 0 whenever `w_load` is low at a clock edge. Rows that were not written keep their old weights.
- R3: For an accepted vector with element `r` at `act_data[8r+7:8r]`, the result holds the signed 32-bit value sum over r of W[r][c]·a[r] at `res_data[32c+31:32c]`.
- R4: When `res_ready` stays high, `res_valid` for a vector rises ROWS+COLS-1 rising edges after its acceptance, counting the acceptance edge itself. With the default 4x4 grid this is 7 edges.
- R5: The grid accepts one vector per cycle and returns results one per cycle, in acceptance order.
- R6: While `res_valid` is high and `res_ready` is low, `res_data` and `res_valid` hold their values and `act_ready` is low.
- R7: Cycles without an accepted vector produce no result. The number of results equals the number of accepted vectors.
- R8: While `w_load` is high, `act_ready` is low. `w_take` is high only when no accepted vector is still awaiting its result, so vectors in flight are computed with the weights that were current when they were accepted.
- R9: Results are exact for the extreme operands -128 and 127 in any combination.
- R10: Stored weights persist across any number of vectors until they are overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| w_load | input | 1 | Weight-load request, level |
| w_row | input | COLS*8 | One row of signed weights, column c at bits 8c+7:8c |
| w_take | output | 1 | The presented weight row is written at this edge |
| act_valid | input | 1 | Activation vector offered |
| act_ready | output | 1 | Grid can accept a vector |
| act_data | input | ROWS*8 | Signed activations, row r at bits 8r+7:8r |
| res_valid | output | 1 | Result vector offered |
| res_ready | input | 1 | Downstream takes the result |
| res_data | output | COLS*32 | Signed column sums, column c at bits 32c+31:32c |

## Verification
An accepted vector's result is due ROWS+COLS-1 edges later as long as the output is never stalled. The bench drives inputs on falling edges and samples every handshake two time units after that edge. It timestamps each acceptance in a scoreboard queue and, during the unstalled stream, requires exactly seven cycles between acceptance and delivery. Under back-pressure the due time stretches by the number of stalled cycles. Here the bench checks order and value only, and checks that a held result stays frozen from one sample to the next. Weight writes are timed off `w_take`. The bench records a weight row as written only in a cycle where it sees `w_take` high, and it requires the scoreboard to be empty at that moment.

// File: rtl/sa_pkg.sv
`timescale 1ns/1ps
package sa_pkg;
  localparam int A_W = 8;
  localparam int S_W = 32;
  typedef logic signed [A_W-1:0] act_t;
  typedef logic signed [S_W-1:0] acc_t;
endpackage

// File: rtl/sa_delay.sv
`timescale 1ns/1ps
module sa_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] st [DEPTH];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int k = 0; k < DEPTH; k++) st[k] <= '0;
        end else if (en) begin
          st[0] <= d;
          for (int k = 1; k < DEPTH; k++) st[k] <= st[k-1];
        end
      end
      assign q = st[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/sa_mac_cell.sv
`timescale 1ns/1ps
module sa_mac_cell
  import sa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic w_we,
  input  act_t w_in,
  input  act_t a_in,
  input  acc_t s_in,
  output acc_t s_out
);
  act_t w_q;
  acc_t prod;

  // sign-extend both operands before the multiply
  assign prod = acc_t'(a_in) * acc_t'(w_q);

  always_ff @(posedge clk) begin
    if (!rst_n)     w_q <= '0;
    else if (w_we)  w_q <= w_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     s_out <= '0;
    else if (adv)   s_out <= s_in + prod;
  end
endmodule

// File: rtl/sa_seq.sv
`timescale 1ns/1ps
module sa_seq #(
  parameter int ROWS = 4,
  parameter int LAT  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            w_load,
  input  logic            act_valid,
  input  logic            res_ready,
  output logic            act_ready,
  output logic            adv,
  output logic            take,
  output logic            w_take,
  output logic            res_valid,
  output logic [ROWS-1:0] row_we
);
  localparam int PW = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [PW-1:0]  ptr;
  logic [LAT-1:0] vld;

  assign res_valid = vld[LAT-1];
  assign adv       = !res_valid || res_ready;
  assign act_ready = !w_load && adv;
  assign take      = act_valid && act_ready;
  assign w_take    = w_load && (vld == '0);

  always_comb begin
    row_we = '0;
    if (w_take) row_we[ptr] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !w_load) ptr <= '0;
    else if (w_take)       ptr <= (ptr == PW'(ROWS-1)) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
    end else if (adv) begin
      vld    <= vld << 1;
      vld[0] <= take;
    end
  end
endmodule

// File: rtl/sa_wsgrid.sv
`timescale 1ns/1ps
module sa_wsgrid
  import sa_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                w_load,
  input  logic [COLS*A_W-1:0] w_row,
  output logic                w_take,
  input  logic                act_valid,
  output logic                act_ready,
  input  logic [ROWS*A_W-1:0] act_data,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [COLS*S_W-1:0] res_data
);
  localparam int LAT = ROWS + COLS - 1;

  logic            adv;
  logic            take;
  logic [ROWS-1:0] row_we;

  sa_seq #(.ROWS(ROWS), .LAT(LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .w_load(w_load), .act_valid(act_valid),
    .res_ready(res_ready), .act_ready(act_ready), .adv(adv), .take(take),
    .w_take(w_take), .res_valid(res_valid), .row_we(row_we)
  );

  // a bubble enters as zeros
  logic [ROWS*A_W-1:0] act_in;
  assign act_in = take ? act_data : '0;

  act_t a_h [ROWS][COLS];
  acc_t s_v [ROWS+1][COLS];

  genvar r, c;
  generate
    for (r = 0; r < ROWS; r++) begin : g_skew
      logic [A_W-1:0] sk_q;
      sa_delay #(.W(A_W), .DEPTH(r)) u_skew (
        .clk(clk), .rst_n(rst_n), .en(adv),
        .d(act_in[r*A_W +: A_W]), .q(sk_q)
      );
      assign a_h[r][0] = act_t'(sk_q);
    end

    for (c = 0; c < COLS; c++) begin : g_top
      assign s_v[0][c] = '0;
    end

    for (r = 0; r < ROWS; r++) begin : g_row
      for (c = 0; c < COLS; c++) begin : g_col
        sa_mac_cell u_cell (
          .clk(clk), .rst_n(rst_n), .adv(adv), .w_we(row_we[r]),
          .w_in(act_t'(w_row[c*A_W +: A_W])), .a_in(a_h[r][c]),
          .s_in(s_v[r][c]), .s_out(s_v[r+1][c])
        );
        if (c < COLS-1) begin : g_fwd
          logic [A_W-1:0] fw_q;
          sa_delay #(.W(A_W), .DEPTH(1)) u_fwd (
            .clk(clk), .rst_n(rst_n), .en(adv),
            .d(a_h[r][c]), .q(fw_q)
          );
          assign a_h[r][c+1] = act_t'(fw_q);
        end
      end
    end

    for (c = 0; c < COLS; c++) begin : g_deskew
      sa_delay #(.W(S_W), .DEPTH(COLS-1-c)) u_dsk (
        .clk(clk), .rst_n(rst_n), .en(adv),
        .d(s_v[ROWS][c]), .q(res_data[c*S_W +: S_W])
      );
    end
  endgenerate
endmodule

// File: rtl/sa_wsgrid_chk.sv
`timescale 1ns/1ps
module sa_wsgrid_chk #(
  parameter int LAT   = 7,
  parameter int DBITS = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             w_load,
  input logic             w_take,
  input logic             act_valid,
  input logic             act_ready,
  input logic             res_valid,
  input logic             res_ready,
  input logic [DBITS-1:0] res_data
);
  logic [15:0] inflight;
  logic acc, del;
  assign acc = act_valid && act_ready;
  assign del = res_valid && res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)          inflight <= '0;
    else if (acc && !del) inflight <= inflight + 16'd1;
    else if (!acc && del) inflight <= inflight - 16'd1;
  end

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data));
  a_r6_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !act_ready);
  a_r8_no_act: assert property (@(posedge clk) disable iff (!rst_n)
    w_load |-> !act_ready);
  a_r8_take_empty: assert property (@(posedge clk) disable iff (!rst_n)
    w_take |-> inflight == 16'd0);
  a_r2_take_load: assert property (@(posedge clk) disable iff (!rst_n)
    w_take |-> w_load);
  a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(inflight) <= LAT);
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> inflight != 16'd0);
endmodule

bind sa_wsgrid sa_wsgrid_chk #(.LAT(ROWS+COLS-1), .DBITS(COLS*32)) u_chk (
  .clk(clk), .rst_n(rst_n), .w_load(w_load), .w_take(w_take),
  .act_valid(act_valid), .act_ready(act_ready), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data)
);

// File: tb/test_sa_wsgrid.sv
`timescale 1ns/1ps
module test_sa_wsgrid;
  localparam int R = 4;
  localparam int C = 4;
  localparam int L = R + C - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic w_load = 1'b0, w_take;
  logic [C*8-1:0] w_row = '0;
  logic act_valid = 1'b0, act_ready;
  logic [R*8-1:0] act_data = '0;
  logic res_valid, res_ready = 1'b1;
  logic [C*32-1:0] res_data;

  sa_wsgrid #(.ROWS(R), .COLS(C)) i_sa_wsgrid (
    .clk(clk), .rst_n(rst_n), .w_load(w_load), .w_row(w_row), .w_take(w_take),
    .act_valid(act_valid), .act_ready(act_ready), .act_data(act_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] wm [R][C];
  logic [31:0] ld [R];
  logic [C*32-1:0] exp_q [$];
  int cyc_q [$];
  string tag = "R3";
  bit lat_on = 0, bp_mode = 0, done = 0;

  task automatic chk(input bit ok, input string req, input logic [C*32-1:0] act, input logic [C*32-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [C*32-1:0] model(input logic [R*8-1:0] a);
    logic [C*32-1:0] o;
    for (int c = 0; c < C; c++) begin
      int s = 0;
      for (int r = 0; r < R; r++)
        s += int'($signed(wm[r][c])) * int'($signed(a[8*r +: 8]));
      o[32*c +: 32] = s;
    end
    return o;
  endfunction

  function automatic logic [31:0] wset(input int set, input int r);
    logic [31:0] v;
    for (int c = 0; c < C; c++) begin
      logic [7:0] b;
      if (set == 1)      b = 8'h80;
      else if (set == 2) b = 8'h7f;
      else if (set == 3) b = ((r + c) % 2 == 1) ? 8'h7f : 8'h80;
      else               b = 8'(set * 29 + r * 17 + c * 43 - 100);
      v[8*c +: 8] = b;
    end
    return v;
  endfunction

  // back-pressure pattern
  initial forever begin
    @(negedge clk);
    res_ready = bp_mode ? (((cyc * 7) % 5) >= 2) : 1'b1;
  end

  // monitor / scoreboard
  bit hold_prev = 0;
  logic [C*32-1:0] held;
  initial forever begin
    @(negedge clk); #2;
    cyc++;
    if (rst_n) begin
      if (hold_prev) chk(res_valid && res_data == held, "R6 held result changed", res_data, held);
      if (res_valid && !res_ready) chk(!act_ready, "R6 accepted while stalled", {127'd0, act_ready}, '0);
      hold_prev = res_valid && !res_ready;
      held = res_data;
      if (res_valid && res_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R7 result without vector", res_data, '0);
        end else begin
          logic [C*32-1:0] e;
          int t;
          e = exp_q.pop_front();
          t = cyc_q.pop_front();
          chk(res_data == e, tag, res_data, e);
          if (lat_on) chk(cyc - t == L, "R4 latency", (C*32)'(cyc - t), (C*32)'(L));
        end
      end
      if (act_valid && act_ready) begin
        exp_q.push_back(model(act_data));
        cyc_q.push_back(cyc);
      end
    end
  end

  task automatic send(input logic [R*8-1:0] v);
    act_valid = 1'b1; act_data = v;
    #1;
    while (!act_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    act_valid = 1'b0;
  endtask

  task automatic load(input int n);
    int k = 0;
    w_load = 1'b1;
    while (k < n) begin
      w_row = ld[k];
      #1;
      chk(!act_ready, "R8 ready during load", {127'd0, act_ready}, '0);
      if (w_take) begin
        chk(exp_q.size() == 0, "R8 write with vector in flight", (C*32)'(exp_q.size()), '0);
        for (int c = 0; c < C; c++) wm[k][c] = ld[k][8*c +: 8];
        k++;
      end
      @(negedge clk);
    end
    w_load = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [R*8-1:0] sweep(input int v, input int k);
    logic [R*8-1:0] a;
    for (int r = 0; r < R; r++) a[8*r +: 8] = 8'(v * (2*r + 1) + 37*r + k);
    return a;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int r = 0; r < R; r++) for (int c = 0; c < C; c++) wm[r][c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!res_valid && act_ready && !w_take, "R1 reset outputs",
        {125'd0, res_valid, act_ready, w_take}, {125'd0, 3'b010});
    @(negedge clk);
    tag = "R1 zero weights";
    send(32'h7f80_1234);
    send(32'h0102_0304);
    drain();

    // R2/R3/R4/R5: load and stream back to back
    for (int r = 0; r < R; r++) ld[r] = wset(4, r);
    load(R);
    tag = "R3 R5 stream"; lat_on = 1;
    for (int v = 0; v < 24; v++) send(sweep(v * 11, 3));
    drain();
    lat_on = 0;

    // R9 extremes
    tag = "R9 extremes";
    for (int s = 1; s <= 3; s++) begin
      for (int r = 0; r < R; r++) ld[r] = wset(s, r);
      load(R);
      send(32'h8080_8080); send(32'h7f7f_7f7f);
      send(32'h7f80_7f80); send(32'h807f_807f); send(32'h0000_0000);
      drain();
    end

    // R3 near-exhaustive sweep of each activation byte
    for (int r = 0; r < R; r++) ld[r] = wset(5, r);
    load(R);
    tag = "R3 sweep";
    for (int v = 0; v < 256; v++) send(sweep(v, 0));
    drain();

    // R6/R7 back-pressure and bubbles
    tag = "R6 R7 stalls"; bp_mode = 1;
    for (int v = 0; v < 60; v++) begin
      send(sweep(v * 5, 9));
      if (v % 3 == 0) repeat (v % 4) @(negedge clk);
    end
    drain();
    bp_mode = 0;
    drain();

    // R8 load requested with vectors in flight
    tag = "R8 old weights";
    send(sweep(1, 1)); send(sweep(2, 2)); send(sweep(3, 3));
    for (int r = 0; r < R; r++) ld[r] = wset(6, r);
    load(R);
    tag = "R8 new weights";
    send(sweep(4, 4)); send(sweep(5, 5));
    drain();

    // R2 pointer restart: partial load then full load
    for (int r = 0; r < R; r++) ld[r] = wset(7, r);
    load(2);
    for (int r = 0; r < R; r++) ld[r] = wset(8, r);
    load(R);
    tag = "R2 restart";
    for (int v = 0; v < 8; v++) send(sweep(v * 31, 7));
    drain();

    // R2/R10 partial overwrite keeps untouched rows
    for (int r = 0; r < R; r++) ld[r] = wset(9, r);
    load(2);
    tag = "R10 persist";
    for (int v = 0; v < 8; v++) send(sweep(v * 17, 2));
    drain();

    chk(exp_q.size() == 0, "R7 outstanding at end", (C*32)'(exp_q.size()), '0);
    finish_run();
  end
endmodule